// File: doc/BRIEF.md
# Static Branch Prediction Fetch Redirector

This block sits between the instruction-fetch address generator and early decode. Each cycle it may receive one pre-decoded branch from the fetch buffer. The branch comes with its own address, a signed displacement (short 8-bit or long 16-bit form) and a flag that marks it as unconditional. The block computes the branch target on the fetch side, using the branch address plus the instruction size plus the sign-extended displacement, forced to halfword alignment. An unconditional branch always redirects fetch to that target. A conditional branch redirects only when a static rule predicts it taken.

The static rule uses the sign of the displacement. A negative displacement means a backward branch, and backward branches are always predicted taken. A zero or positive displacement means a forward branch, which is predicted not-taken unless the run-time control input `fwd_pred_taken` is set. Execute reports resolved branches. When it flags a misprediction, the block redirects fetch to the correct address and pulses a flush of younger fetched instructions. A misprediction outranks any prediction made in the same cycle.

All outputs are registered. A redirect appears on the clock edge after the branch is presented, so an unconditional branch costs a single cycle.

Top module: `brpred_redirect`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `redir_vld` and `flush_younger` are 0.
- R2: An unconditional branch (`br_vld=1`, `br_uncond=1`) with no mispredict in the same cycle gives `redir_vld=1` for exactly one cycle, one clock edge later, with `redir_addr` equal to the computed target.
- R3: The target is `br_pc + 2 + sign_extend(displacement)` with bit 0 forced to 0.
- R4: When `br_long=0` only `br_disp[7:0]` is used, sign-extended from bit 7, and bits 15:8 are ignored. When `br_long=1` all of `br_disp[15:0]` is used, sign-extended from bit 15.
- R5: A conditional branch whose selected displacement is negative (backward) redirects to its target whatever the value of `fwd_pred_taken`.
- R6: A conditional branch whose selected displacement is zero or positive (forward) gives no redirect when `fwd_pred_taken=0`.
- R7: A forward conditional branch redirects to its target when `fwd_pred_taken=1`.
- R8: A displacement of exactly zero counts as forward.
- R9: `rslv_vld=1` with `rslv_mispred=1` gives, one edge later, `redir_vld=1` and `flush_younger=1`. `redir_addr` is `rslv_target` if `rslv_taken=1` and `rslv_next` otherwise.
- R10: When a mispredict and a branch arrive in the same cycle, the mispredict address wins and the flush is raised.
- R11: `rslv_vld=1` with `rslv_mispred=0` and no branch gives no redirect and no flush.
- R12: A redirect caused by a prediction never raises `flush_younger`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_vld | input | 1 | A pre-decoded branch is presented |
| br_uncond | input | 1 | Branch is unconditional |
| br_long | input | 1 | Use the 16-bit displacement; otherwise use the low 8 bits |
| br_pc | input | ADDR_W | Address of the branch instruction |
| br_disp | input | DISP_W | Raw displacement field |
| fwd_pred_taken | input | 1 | Predict forward conditional branches taken |
| rslv_vld | input | 1 | Execute reports a resolved branch |
| rslv_mispred | input | 1 | The resolved branch was mispredicted |
| rslv_taken | input | 1 | Actual outcome of the resolved branch |
| rslv_target | input | ADDR_W | Taken address of the resolved branch |
| rslv_next | input | ADDR_W | Fall-through address of the resolved branch |
| redir_vld | output | 1 | Fetch redirect strobe |
| redir_addr | output | ADDR_W | New fetch address |
| flush_younger | output | 1 | Discard younger fetched instructions |

## Verification
Every result of this block is due on the single clock edge that follows its stimulus, because the redirect strobe, address and flush all come from one register stage. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, half a cycle after the capturing rising edge. It then drops the branch and resolve inputs and samples again one cycle later, which confirms that every strobe lasts exactly one cycle. The table of branch vectors and the directed mispredict cases all use this same one-cycle sampling point.

// File: rtl/brp_pkg.sv
package brp_pkg;
  typedef enum logic [1:0] {
    RS_NONE = 2'd0,
    RS_PRED = 2'd1,
    RS_FIX  = 2'd2
  } redir_src_e;
endpackage

// File: rtl/brp_target_gen.sv
module brp_target_gen #(
  parameter int ADDR_W     = 32,
  parameter int DISP_W     = 16,
  parameter int SHORT_W    = 8,
  parameter int INSN_BYTES = 2,
  parameter int ALIGN_LOG2 = 1
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              use_long,
  output logic [ADDR_W-1:0] target,
  output logic              backward
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  function automatic logic [ADDR_W-1:0] sext_short(input logic [DISP_W-1:0] d);
    return {{(ADDR_W-SHORT_W){d[SHORT_W-1]}}, d[SHORT_W-1:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] sext_long(input logic [DISP_W-1:0] d);
    return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] raw_sum;

  assign offset   = use_long ? sext_long(disp) : sext_short(disp);
  assign backward = offset[ADDR_W-1];
  assign raw_sum  = pc + STEP + offset;

  generate
    if (ALIGN_LOG2 > 0) begin : g_align
      assign target = {raw_sum[ADDR_W-1:ALIGN_LOG2], {ALIGN_LOG2{1'b0}}};
    end else begin : g_noalign
      assign target = raw_sum;
    end
  endgenerate
endmodule

// File: rtl/brp_dir_rule.sv
module brp_dir_rule (
  input  logic uncond,
  input  logic backward,
  input  logic fwd_ctl,
  output logic take
);
  logic cond_take;
  assign cond_take = backward ? 1'b1 : fwd_ctl;
  assign take      = uncond | cond_take;
endmodule

// File: rtl/brp_redir_arb.sv
module brp_redir_arb
  import brp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_LOG2 = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_fire,
  input  logic [ADDR_W-1:0] pred_addr,
  input  logic              fix_fire,
  input  logic [ADDR_W-1:0] fix_addr,
  output logic              redir_vld,
  output logic [ADDR_W-1:0] redir_addr,
  output logic              flush_younger
);
  logic       take_fix;
  logic       take_pred;
  redir_src_e src_d, src_q;

  assign take_fix  = fix_fire;
  assign take_pred = pred_fire & ~fix_fire;

  always_comb begin
    if (take_fix)       src_d = RS_FIX;
    else if (take_pred) src_d = RS_PRED;
    else                src_d = RS_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q         <= RS_NONE;
      redir_vld     <= 1'b0;
      flush_younger <= 1'b0;
      redir_addr    <= '0;
    end else begin
      src_q         <= src_d;
      redir_vld     <= (src_d != RS_NONE);
      flush_younger <= (src_d == RS_FIX);
      if (src_d == RS_FIX)       redir_addr <= fix_addr;
      else if (src_d == RS_PRED) redir_addr <= pred_addr;
    end
  end

  p_flush_has_redir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_younger |-> redir_vld);

  p_fix_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_fix |=> (flush_younger && redir_addr == $past(fix_addr)));

  p_pred_no_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    take_pred |=> (redir_vld && !flush_younger && redir_addr == $past(pred_addr)));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_fix && !take_pred) |=> (!redir_vld && !flush_younger));

  generate
    if (ALIGN_LOG2 > 0) begin : g_align_chk
      p_pred_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == RS_PRED) |-> (redir_addr[ALIGN_LOG2-1:0] == '0));
    end
  endgenerate
endmodule

// File: rtl/brpred_redirect.sv
module brpred_redirect #(
  parameter int ADDR_W     = 32,
  parameter int DISP_W     = 16,
  parameter int SHORT_W    = 8,
  parameter int INSN_BYTES = 2,
  parameter int ALIGN_LOG2 = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_vld,
  input  logic              br_uncond,
  input  logic              br_long,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [DISP_W-1:0] br_disp,
  input  logic              fwd_pred_taken,
  input  logic              rslv_vld,
  input  logic              rslv_mispred,
  input  logic              rslv_taken,
  input  logic [ADDR_W-1:0] rslv_target,
  input  logic [ADDR_W-1:0] rslv_next,
  output logic              redir_vld,
  output logic [ADDR_W-1:0] redir_addr,
  output logic              flush_younger
);
  logic [ADDR_W-1:0] tgt_addr;
  logic              is_backward;
  logic              pred_take;
  logic              pred_fire;
  logic              fix_fire;
  logic [ADDR_W-1:0] fix_addr;

  brp_target_gen #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .SHORT_W(SHORT_W),
    .INSN_BYTES(INSN_BYTES), .ALIGN_LOG2(ALIGN_LOG2)
  ) u_tgt (
    .pc(br_pc), .disp(br_disp), .use_long(br_long),
    .target(tgt_addr), .backward(is_backward)
  );

  brp_dir_rule u_dir (
    .uncond(br_uncond), .backward(is_backward),
    .fwd_ctl(fwd_pred_taken), .take(pred_take)
  );

  assign pred_fire = br_vld & pred_take;
  assign fix_fire  = rslv_vld & rslv_mispred;
  assign fix_addr  = rslv_taken ? rslv_target : rslv_next;

  brp_redir_arb #(.ADDR_W(ADDR_W), .ALIGN_LOG2(ALIGN_LOG2)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .pred_fire(pred_fire), .pred_addr(tgt_addr),
    .fix_fire(fix_fire), .fix_addr(fix_addr),
    .redir_vld(redir_vld), .redir_addr(redir_addr),
    .flush_younger(flush_younger)
  );

  p_uncond_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (br_vld && br_uncond && !fix_fire) |=> (redir_vld && redir_addr == $past(tgt_addr)));

  p_backward_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_vld && is_backward && !fix_fire) |=> redir_vld);

  p_fwd_clear_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_vld && !br_uncond && !is_backward && !fwd_pred_taken && !fix_fire) |=> !redir_vld);

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_vld && !fix_fire) |=> !redir_vld);
endmodule

// File: tb/brpred_redirect_test.sv
module brpred_redirect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_vld = 1'b0, br_uncond = 1'b0, br_long = 1'b0;
  logic [31:0] br_pc = '0;
  logic [15:0] br_disp = '0;
  logic        fwd_pred_taken = 1'b0;
  logic        rslv_vld = 1'b0, rslv_mispred = 1'b0, rslv_taken = 1'b0;
  logic [31:0] rslv_target = '0, rslv_next = '0;
  logic        redir_vld, flush_younger;
  logic [31:0] redir_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  brpred_redirect uut (
    .clk(clk), .rst_n(rst_n), .br_vld(br_vld), .br_uncond(br_uncond),
    .br_long(br_long), .br_pc(br_pc), .br_disp(br_disp),
    .fwd_pred_taken(fwd_pred_taken), .rslv_vld(rslv_vld),
    .rslv_mispred(rslv_mispred), .rslv_taken(rslv_taken),
    .rslv_target(rslv_target), .rslv_next(rslv_next),
    .redir_vld(redir_vld), .redir_addr(redir_addr), .flush_younger(flush_younger)
  );

  // {uncond, long, ctl, exp_vld, disp[15:0], pc[31:0], exp_addr[31:0]}
  localparam int NV = 13;
  localparam logic [83:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b1,16'h0010,32'h0000_1000,32'h0000_1012},
    {1'b1,1'b0,1'b1,1'b1,16'h00F0,32'h0000_1000,32'h0000_0FF2},
    {1'b0,1'b0,1'b0,1'b0,16'h0020,32'h0000_1000,32'h0000_0000},
    {1'b0,1'b0,1'b1,1'b1,16'h0020,32'h0000_1000,32'h0000_1022},
    {1'b0,1'b0,1'b0,1'b1,16'h00FC,32'h0000_2000,32'h0000_1FFE},
    {1'b0,1'b0,1'b1,1'b1,16'h00FC,32'h0000_2000,32'h0000_1FFE},
    {1'b0,1'b1,1'b1,1'b1,16'h0400,32'h0000_1000,32'h0000_1402},
    {1'b0,1'b1,1'b0,1'b1,16'hFF00,32'h0000_1000,32'h0000_0F02},
    {1'b0,1'b1,1'b0,1'b0,16'h0400,32'h0000_1000,32'h0000_0000},
    {1'b0,1'b0,1'b0,1'b0,16'h0000,32'h0000_3000,32'h0000_0000},
    {1'b0,1'b0,1'b1,1'b1,16'h0000,32'h0000_3000,32'h0000_3002},
    {1'b1,1'b0,1'b0,1'b1,16'h0005,32'h0000_1000,32'h0000_1006},
    {1'b1,1'b0,1'b0,1'b1,16'h7F80,32'h0000_1000,32'h0000_0F82}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1:   return "R2";
      2:      return "R6";
      3:      return "R7";
      4, 5:   return "R5";
      6:      return "R4";
      7:      return "R4";
      8:      return "R6";
      9, 10:  return "R8";
      11:     return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    br_vld = 0; br_uncond = 0; br_long = 0; br_disp = '0;
    rslv_vld = 0; rslv_mispred = 0; rslv_taken = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1", "redir_vld in reset", 32'(redir_vld), 0);
    check("R1", "flush in reset", 32'(flush_younger), 0);
    rst_n = 1;
    step();
    check("R1", "redir_vld after reset", 32'(redir_vld), 0);
    check("R1", "flush after reset", 32'(flush_younger), 0);

    for (int i = 0; i < NV; i++) begin
      logic [83:0] v;
      v = VEC[i];
      br_vld = 1; br_uncond = v[83]; br_long = v[82]; fwd_pred_taken = v[81];
      br_disp = v[79:64]; br_pc = v[63:32];
      step();
      idle_inputs();
      check(vec_tag(i), "redir_vld", 32'(redir_vld), 32'(v[80]));
      if (v[80]) check(vec_tag(i), "redir_addr", redir_addr, v[31:0]);
      check("R12", "no flush on prediction", 32'(flush_younger), 0);
      step();
      check("R2", "strobe is one cycle", 32'(redir_vld), 0);
    end

    // mispredict, actual taken
    rslv_vld = 1; rslv_mispred = 1; rslv_taken = 1;
    rslv_target = 32'h0000_4444; rslv_next = 32'h0000_5556;
    step(); idle_inputs();
    check("R9", "redir_vld taken fix", 32'(redir_vld), 1);
    check("R9", "flush taken fix", 32'(flush_younger), 1);
    check("R9", "addr taken fix", redir_addr, 32'h0000_4444);
    step();
    check("R9", "flush one cycle", 32'(flush_younger), 0);

    // mispredict, actual not taken
    rslv_vld = 1; rslv_mispred = 1; rslv_taken = 0;
    step(); idle_inputs();
    check("R9", "addr not-taken fix", redir_addr, 32'h0000_5556);
    check("R9", "flush not-taken fix", 32'(flush_younger), 1);
    step();

    // mispredict together with an unconditional branch
    br_vld = 1; br_uncond = 1; br_pc = 32'h0000_1000; br_disp = 16'h0010;
    rslv_vld = 1; rslv_mispred = 1; rslv_taken = 1; rslv_target = 32'h0000_7770;
    step(); idle_inputs();
    check("R10", "fix address wins", redir_addr, 32'h0000_7770);
    check("R10", "flush on collision", 32'(flush_younger), 1);
    step();

    // correct resolution, no branch
    rslv_vld = 1; rslv_mispred = 0; rslv_taken = 1;
    step(); idle_inputs();
    check("R11", "no redirect on correct", 32'(redir_vld), 0);
    check("R11", "no flush on correct", 32'(flush_younger), 0);

    // backward long branch with control set, flags no flush
    br_vld = 1; br_uncond = 0; br_long = 1; fwd_pred_taken = 1;
    br_pc = 32'h0000_8000; br_disp = 16'h8000;
    step(); idle_inputs();
    check("R5", "long backward addr", redir_addr, 32'h0000_0002);
    check("R12", "long backward no flush", 32'(flush_younger), 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule